// File: doc/BRIEF.md
# Dual-Channel Compare Timer

An 8-bit up-counter advanced by a prescaled tick, with two compare channels (A and B). A waveform field picks between a free-running count that wraps through 0xFF and a clear-on-compare count. In the clear-on-compare count, channel A's compare value is the last count before the counter returns to zero, so it sets the period. Each channel raises its own sticky match flag. Each channel also has an interrupt enable and can act on its own output pin when it matches: set, clear or toggle.

Software reaches the block through a register port with one write per cycle and a combinational read. Compare values can be rewritten at any time. In the free-running count, adding a fixed step to a channel's compare value after each of its matches gives that channel a steady period of its own, with the sum wrapping modulo 256. In the clear-on-compare count, a channel B value above channel A's is never reached and never matches.

Register map (byte wide; `wr_addr` and `rd_addr` select it):

| Addr | Content |
|------|---------|
| 0 | bits [1:0] channel A pin action, bits [3:2] channel B pin action, bits [6:4] waveform code |
| 1 | bits [2:0] tick rate select |
| 2 | counter value (a write loads it) |
| 3 | channel A compare value |
| 4 | channel B compare value |
| 5 | interrupt enables: bit 0 channel A, bit 1 channel B |
| 6 | match flags: bit 0 channel A, bit 1 channel B (a write of 1 clears) |

Top module: `cmp_timer8`

## Requirements
- R1: After reset the counter, all registers, both flags and both pins read zero, and `irq` is low.
- R2: A free-running 10-bit prescale count starts at zero after reset and advances every clock. Rate select 001 ticks every clock. Select 010 ticks when the low 3 prescale bits are all ones, 011 when the low 6 are, 100 when the low 8 are, and 101 when all 10 are. Select 000, 110 and 111 give no tick, and the counter holds.
- R3: With any waveform code other than 010, each tick adds one to the counter, and 0xFF goes to 0x00.
- R4: With waveform code 010, a tick taken while the counter equals the channel A compare value loads zero instead of incrementing.
- R5: With waveform code 010 and a channel B compare value above channel A's, the counter started at or below A's value never causes a channel B match and flag B stays clear.
- R6: A channel matches on a tick when the counter value before that tick equals its compare value. The match sets the channel's flag at the same edge as the counter update.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. If a match happens in the same cycle as the clear, the flag is set.
- R8: `irq` is high exactly when some channel has both its flag and its enable set.
- R9: Pin action 00 holds the pin low and leaves its state untouched. 01 inverts the pin state on each match, 10 clears it and 11 sets it.
- R10: A compare write takes effect at once and produces no match by itself. A counter write loads the value and cancels that cycle's tick, so there is no increment and no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| cmp_out_a | output | 1 | Channel A compare pin |
| cmp_out_b | output | 1 | Channel B compare pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench steers channel B above channel A in the clear-on-compare count. A design that compared against a fixed top, or that let channel B's value end the period, would raise flag B there. It also stacks a flag clear on top of a match in the same cycle, and writes the counter while ticks are running. A design where the clear wins would drop an event, and one that still advances after a load would read back one too high. Long runs at the slower rates check the wrap through 0xFF and the exact tick spacing, which catches an off-by-one in the prescale taps.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;

   typedef enum logic [1:0] {
      PA_OFF = 2'b00,
      PA_TOG = 2'b01,
      PA_CLR = 2'b10,
      PA_SET = 2'b11
   } pin_act_e;

   localparam logic [2:0] WAVE_CLR_ON_A = 3'b010;

   localparam logic [2:0] RA_CFG  = 3'd0;
   localparam logic [2:0] RA_RATE = 3'd1;
   localparam logic [2:0] RA_CNT  = 3'd2;
   localparam logic [2:0] RA_CMPA = 3'd3;
   localparam logic [2:0] RA_CMPB = 3'd4;
   localparam logic [2:0] RA_IEN  = 3'd5;
   localparam logic [2:0] RA_FLG  = 3'd6;

   localparam int unsigned NUM_RATES = 5;
   localparam int unsigned RATE_SHIFT [NUM_RATES] = '{0, 3, 6, 8, 10};

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler
   import cmp_timer8_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] rate,
   output logic       tick
);

   logic [PRE_W-1:0]     pre;
   logic [NUM_RATES-1:0] taps;

   if (PRE_W < RATE_SHIFT[NUM_RATES-1]) begin : g_bad_width
      $error("ct_prescaler: PRE_W too small for the slowest rate");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre <= '0;
      else        pre <= pre + 1'b1;
   end

   for (genvar k = 0; k < NUM_RATES; k++) begin : g_tap
      localparam int unsigned SH = RATE_SHIFT[k];
      if (SH == 0) begin : g_every
         assign taps[k] = 1'b1;
      end else begin : g_mask
         assign taps[k] = &pre[SH-1:0];
      end
   end

   always_comb begin
      if (rate >= 3'd1 && rate <= 3'(NUM_RATES))
         tick = taps[rate - 3'd1];
      else
         tick = 1'b0;
   end

endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_on_top,
   input  logic [CNT_W-1:0] top_val,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);

   logic at_top;
   assign at_top = clr_on_top && (cnt == top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (tick)  cnt <= at_top ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/ct_channel.sv
module ct_channel
   import cmp_timer8_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [1:0]       act,
   output logic             match,
   output logic             pin
);

   logic state;

   assign match = tick && !hold && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= 1'b0;
      else if (match) begin
         case (pin_act_e'(act))
            PA_TOG:  state <= ~state;
            PA_CLR:  state <= 1'b0;
            PA_SET:  state <= 1'b1;
            default: state <= state;
         endcase
      end
   end

   assign pin = (pin_act_e'(act) == PA_OFF) ? 1'b0 : state;

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
   import cmp_timer8_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             cmp_out_a,
   output logic             cmp_out_b,
   output logic             irq
);

   localparam int unsigned NCH = 2;

   if (CNT_W < 8) begin : g_bad_cnt
      $error("cmp_timer8: CNT_W must hold the configuration byte");
   end

   logic [NCH-1:0][1:0]       act;
   logic [2:0]                wave;
   logic [2:0]                rate;
   logic [NCH-1:0][CNT_W-1:0] cmp;
   logic [NCH-1:0]            ien, flg, match, pin;
   logic [CNT_W-1:0]          cnt;
   logic                      tick, ctc, cnt_load;

   assign ctc      = (wave == WAVE_CLR_ON_A);
   assign cnt_load = wr_en && (wr_addr == RA_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= '0;
         wave <= '0;
         rate <= '0;
         cmp  <= '0;
         ien  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_CFG:  begin
               act[0] <= wr_data[1:0];
               act[1] <= wr_data[3:2];
               wave   <= wr_data[6:4];
            end
            RA_RATE: rate   <= wr_data[2:0];
            RA_CMPA: cmp[0] <= wr_data;
            RA_CMPB: cmp[1] <= wr_data;
            RA_IEN:  ien    <= wr_data[NCH-1:0];
            default: ;
         endcase
      end
   end

   ct_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .rate (rate),
      .tick (tick)
   );

   ct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .clr_on_top(ctc),
      .top_val   (cmp[0]),
      .load      (cnt_load),
      .load_val  (wr_data),
      .cnt       (cnt)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      ct_channel #(.CNT_W(CNT_W)) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .hold (cnt_load),
         .cnt  (cnt),
         .cmp  (cmp[i]),
         .act  (act[i]),
         .match(match[i]),
         .pin  (pin[i])
      );
   end

   logic [NCH-1:0] flg_clr;
   assign flg_clr = (wr_en && wr_addr == RA_FLG) ? wr_data[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg <= '0;
      else        flg <= (flg & ~flg_clr) | match;
   end

   always_comb begin
      case (rd_addr)
         RA_CFG:  rd_data = CNT_W'({1'b0, wave, act[1], act[0]});
         RA_RATE: rd_data = CNT_W'(rate);
         RA_CNT:  rd_data = cnt;
         RA_CMPA: rd_data = cmp[0];
         RA_CMPB: rd_data = cmp[1];
         RA_IEN:  rd_data = CNT_W'(ien);
         RA_FLG:  rd_data = CNT_W'(flg);
         default: rd_data = '0;
      endcase
   end

   assign cmp_out_a = pin[0];
   assign cmp_out_b = pin[1];
   assign irq       = |(flg & ien);

endmodule

// File: rtl/cmp_timer8_chk.sv
module cmp_timer8_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             ctc,
   input logic             cnt_load,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_a,
   input logic [CNT_W-1:0] cmp_b,
   input logic             match_a,
   input logic             match_b,
   input logic [1:0]       flg,
   input logic [1:0]       ien,
   input logic [1:0]       act_a,
   input logic             pin_a,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             irq
);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_load) |=> $stable(cnt));

   p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctc && tick && !cnt_load && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

   p_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctc && tick && !cnt_load && cnt == cmp_a) |=> (cnt == '0));

   p_b_unreached_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctc && cmp_b > cmp_a && cnt <= cmp_a) |-> !match_b);

   p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match_a |=> flg[0]);

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd6 && wr_data[0] && !match_a) |=> !flg[0]);

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 2'b00) |-> !irq);

   p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a && act_a == 2'b01 && !(wr_en && wr_addr == 3'd0)) |=> (pin_a != $past(pin_a)));

endmodule

bind cmp_timer8 cmp_timer8_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .ctc     (ctc),
   .cnt_load(cnt_load),
   .cnt     (cnt),
   .cmp_a   (cmp[0]),
   .cmp_b   (cmp[1]),
   .match_a (match[0]),
   .match_b (match[1]),
   .flg     (flg),
   .ien     (ien),
   .act_a   (act[0]),
   .pin_a   (pin[0]),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .irq     (irq)
);

// File: tb/sim_cmp_timer8.sv
`timescale 1ns/1ps
module sim_cmp_timer8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cmp_out_a, cmp_out_b, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmp_timer8 u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b), .irq(irq)
   );

   // reference state, advanced from the requirements
   logic [1:0] m_act_a, m_act_b;
   logic [2:0] m_wave, m_rate;
   logic [7:0] m_cnt, m_ca, m_cb;
   logic [1:0] m_ien, m_flg;
   logic       m_sa, m_sb;
   int         m_pre;

   function automatic bit rate_tick(input logic [2:0] r, input int p);
      case (r)
         3'd1: return 1'b1;
         3'd2: return (p % 8) == 7;
         3'd3: return (p % 64) == 63;
         3'd4: return (p % 256) == 255;
         3'd5: return (p % 1024) == 1023;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic pin_next(input logic [1:0] a, input logic m, input logic s);
      if (!m) return s;
      case (a)
         2'b01: return ~s;
         2'b10: return 1'b0;
         2'b11: return 1'b1;
         default: return s;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act_a = 0; m_act_b = 0; m_wave = 0; m_rate = 0;
         m_cnt = 0; m_ca = 0; m_cb = 0; m_ien = 0; m_flg = 0;
         m_sa = 0; m_sb = 0; m_pre = 0;
      end else begin
         bit t, ld, ma, mb;
         logic [1:0] clr;
         t  = rate_tick(m_rate, m_pre);
         m_pre = (m_pre + 1) % 1024;
         ld = wr_en && wr_addr == 3'd2;
         ma = t && !ld && m_cnt == m_ca;
         mb = t && !ld && m_cnt == m_cb;
         if (t && !ld)
            m_cnt = (m_wave == 3'b010 && m_cnt == m_ca) ? 8'd0 : m_cnt + 8'd1;
         m_sa = pin_next(m_act_a, ma, m_sa);
         m_sb = pin_next(m_act_b, mb, m_sb);
         clr = (wr_en && wr_addr == 3'd6) ? wr_data[1:0] : 2'b00;
         m_flg = (m_flg & ~clr) | {mb, ma};
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_act_a = wr_data[1:0]; m_act_b = wr_data[3:2]; m_wave = wr_data[6:4]; end
               3'd1: m_rate = wr_data[2:0];
               3'd2: m_cnt = wr_data;
               3'd3: m_ca = wr_data;
               3'd4: m_cb = wr_data;
               3'd5: m_ien = wr_data[1:0];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare outputs against the reference; called just after a falling edge
   task automatic check_all();
      rd_addr = 3'd2; #0.2;
      chk("R3 counter", rd_data, m_cnt);
      rd_addr = 3'd6; #0.2;
      chk("R6 flags", rd_data, {6'b0, m_flg});
      chk("R9 pin A", cmp_out_a, (m_act_a == 2'b00) ? 0 : m_sa);
      chk("R9 pin B", cmp_out_b, (m_act_b == 2'b00) ? 0 : m_sb);
      chk("R8 irq", irq, |(m_flg & m_ien));
   endtask

   task automatic cyc(input bit w, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      check_all();
      wr_en = w; wr_addr = a; wr_data = d;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cyc(1'b1, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      for (int a = 0; a < 7; a++) begin
         rd_addr = 3'(a); #0.1;
         chk("R1 reset register", rd_data, 0);
      end
      chk("R1 reset irq", irq, 0);
      chk("R1 reset pin A", cmp_out_a, 0);
      rst_n = 1'b1;

      // R4/R6/R9: clear-on-compare with A=10, B=5, rate every clock
      wr(3'd3, 8'd10); wr(3'd4, 8'd5);
      wr(3'd0, {1'b0, 3'b010, 2'b11, 2'b01});
      wr(3'd5, 8'd3);
      wr(3'd1, 8'd1);
      idle(60);

      // R7: clear while matching, set wins
      for (int i = 0; i < 30; i++) wr(3'd6, 8'd3);
      idle(5);

      // R5: B above A in clear-on-compare
      wr(3'd6, 8'd3); wr(3'd3, 8'd5); wr(3'd4, 8'd200); wr(3'd2, 8'd0);
      wr(3'd6, 8'd3);
      idle(300);
      rd_addr = 3'd6; #0.1;
      chk("R5 flag B never set", rd_data[1], 0);

      // R3/R2: free-running at divide-by-8, through the wrap
      wr(3'd0, 8'h05); wr(3'd1, 8'd2);
      idle(2200);

      // R2: reserved rate holds
      wr(3'd1, 8'd6);
      idle(40);
      // R10: compare write equal to the held count makes no match
      wr(3'd6, 8'd3); wr(3'd2, 8'd7); wr(3'd3, 8'd7);
      idle(5);
      rd_addr = 3'd6; #0.1;
      chk("R10 no match from write", rd_data[0], 0);

      // R10: load while running at full rate
      wr(3'd1, 8'd1); idle(3); wr(3'd2, 8'h30); idle(3);

      // R10: stepped compares in free-running mode
      wr(3'd0, 8'h05); wr(3'd3, 8'd0); wr(3'd4, 8'd0); wr(3'd6, 8'd3);
      for (int i = 0; i < 1500; i++) begin
         if (m_flg[0]) begin wr(3'd3, m_ca + 8'd37); wr(3'd6, 8'd1); end
         else if (m_flg[1]) begin wr(3'd4, m_cb + 8'd90); wr(3'd6, 8'd2); end
         else idle(1);
      end

      // random mix
      for (int i = 0; i < 20000; i++) begin
         if ($urandom % 8 == 0) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom % 7);
            d = 8'($urandom);
            if (a == 3'd1) d = ($urandom % 4 != 0) ? 8'(1 + $urandom % 2) : 8'($urandom % 8);
            if (a == 3'd0) d[6:4] = ($urandom % 2) ? 3'b010 : (($urandom % 4 == 0) ? 3'($urandom) : 3'b000);
            wr(a, d);
         end else idle(1);
      end
      idle(2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule